// File: doc/BRIEF.md
# Prioritized Programmable Chip-Select Decoder

This block turns a 24-bit bus address into four active-low select lines for external devices. Each of the four channels has its own small set of registers: a control byte, a lower and an upper window bound, and an I/O base. A channel serves either the memory space or the I/O space, never both. In memory mode it claims a range of 64 KB pages. In I/O mode it claims one 256-byte block.

A memory channel steps aside whenever the on-chip RAM or the on-chip Flash decoder reports a hit on the same address. When several channels match at once, the lowest-numbered one wins. The block drives the selected line, drives the memory-request strobe for memory selects, and passes the read and write strobes through.

A per-channel wait-state count of 0 to 7 stretches an access. While the count runs down, the block raises a wait output and freezes every bus output.

Top module: `csel_decoder`

## Requirements
- R1: After a synchronous reset, every channel's registers read zero. Every channel is therefore disabled and in memory mode, and all outputs are deasserted: cs_n all ones, mreq_n, rd_n and wr_n high, and bus_wait low.
- R2: A channel asserts its select only while its enable bit, control bit 3, is 1.
- R3: A memory-mode channel (control bit 4 = 0) matches when mem_req is high and its lower bound <= addr[23:16] <= its upper bound. Both bounds are inclusive.
- R4: An I/O-mode channel (control bit 4 = 1) matches only when io_req is high and addr[15:8] equals its I/O base. Its select never drives mreq_n low.
- R5: ram_hit or flash_hit blocks every memory-mode match. Neither flag has any effect on I/O-mode matches.
- R6: At most one select is low at a time. When windows overlap, the lowest-numbered matching channel wins.
- R7: mreq_n goes low only with a memory-mode select. rd_n follows rd and wr_n follows wr, each inverted, but only while some select is asserted. Otherwise both stay high.
- R8: All outputs are registered. They show the decode of the inputs and registers from the preceding clock edge. A register write is used from the cycle after it.
- R9: The wait count sits in control bits [7:5]. When an access starts (mem_req or io_req rises) and the winning channel has a nonzero count N, bus_wait is high for N cycles. During those cycles all bus outputs hold the values latched at the start.
- R10: Register write port: cfg_chan picks the channel, and cfg_sel picks the register (0 control, 1 lower bound, 2 upper bound, 3 I/O base). The write happens on a clock edge with cfg_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_chan | input | 2 | Channel for the register write |
| cfg_sel | input | 2 | Register select within the channel |
| cfg_wdata | input | 8 | Register write data |
| addr | input | 24 | Bus address |
| mem_req | input | 1 | Memory access cycle in progress |
| io_req | input | 1 | I/O access cycle in progress |
| rd | input | 1 | Read direction |
| wr | input | 1 | Write direction |
| ram_hit | input | 1 | On-chip RAM claims the address |
| flash_hit | input | 1 | On-chip Flash claims the address |
| cs_n | output | 4 | Active-low selects, bit k for channel k |
| mreq_n | output | 1 | Active-low memory request |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_wait | output | 1 | High while wait states are counting |

## Verification
The bench probes both inclusive edges of each window. A design with an off-by-one compare would drop the select at exactly the lower or upper page. An overlap address tests priority: a wrong priority order selects channel 1 there instead of channel 0. A memory address whose upper byte equals the I/O base checks that an I/O channel ignores memory requests. An I/O access sent with ram_hit set shows whether the suppression leaks into I/O space, which would wrongly cut off the select. A three-state wait run changes the address partway through. A design that does not freeze its outputs would switch selects early, and a design with a miscounted wait would release bus_wait one cycle off.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int REG_W     = 8;
  localparam int CTL_EN    = 3;
  localparam int CTL_IO    = 4;
  localparam int CTL_WS_LO = 5;
  localparam int WS_W      = 3;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_LO  = 2'd1,
    SEL_HI  = 2'd2,
    SEL_IOB = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [REG_W-1:0] ctl;
    logic [REG_W-1:0] lo;
    logic [REG_W-1:0] hi;
    logic [REG_W-1:0] iob;
  } chan_regs_t;

endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [CH_W-1:0]         chan,
  input  logic [1:0]              sel,
  input  logic [REG_W-1:0]        wdata,
  output chan_regs_t [NUM_CH-1:0] regs
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    chan_regs_t r_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        r_q <= '0;
      end else if (we && (chan == CH_W'(g))) begin
        unique case (cfg_sel_e'(sel))
          SEL_CTL: r_q.ctl <= wdata;
          SEL_LO:  r_q.lo  <= wdata;
          SEL_HI:  r_q.hi  <= wdata;
          SEL_IOB: r_q.iob <= wdata;
        endcase
      end
    end

    assign regs[g] = r_q;

    AST_RST_CLEARS_CTL: assert property (@(posedge clk)
      rst |=> (r_q == '0)); // R1
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (we && chan == CH_W'(g) && sel == 2'd0) |=> (r_q.ctl == $past(wdata))); // R10
  end

endmodule

// File: rtl/csel_chan_match.sv
module csel_chan_match
  import csel_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int PG_HI = ADDR_W - 1,
  localparam int PG_LO = ADDR_W - REG_W,
  localparam int IO_HI = PG_LO - 1,
  localparam int IO_LO = PG_LO - REG_W
) (
  input  chan_regs_t        regs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              ram_hit,
  input  logic              flash_hit,
  output logic              hit,
  output logic              is_io,
  output logic [WS_W-1:0]   ws
);

  logic             en;
  logic [REG_W-1:0] page;
  logic [REG_W-1:0] blk;
  logic             in_window;
  logic             mem_hit;
  logic             io_hit;
  logic             onchip_claim;

  always_comb begin
    en           = regs.ctl[CTL_EN];
    is_io        = regs.ctl[CTL_IO];
    ws           = regs.ctl[CTL_WS_LO +: WS_W];
    page         = addr[PG_HI:PG_LO];
    blk          = addr[IO_HI:IO_LO];
    in_window    = (page >= regs.lo) && (page <= regs.hi);
    onchip_claim = ram_hit || flash_hit;
    mem_hit      = !is_io && mem_req && in_window && !onchip_claim;
    io_hit       = is_io && io_req && (blk == regs.iob);
    hit          = en && (mem_hit || io_hit);
  end

endmodule

// File: rtl/csel_prio.sv
module csel_prio
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]           hit,
  input  logic [NUM_CH-1:0]           is_io,
  input  logic [NUM_CH-1:0][WS_W-1:0] ws,
  output logic                        win_valid,
  output logic [CH_W-1:0]             win_idx,
  output logic                        win_io,
  output logic [WS_W-1:0]             win_ws
);

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_io    = 1'b0;
    win_ws    = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (hit[k]) begin
        win_valid = 1'b1;
        win_idx   = CH_W'(k);
        win_io    = is_io[k];
        win_ws    = ws[k];
      end
    end
  end

endmodule

// File: rtl/csel_strobe.sv
module csel_strobe
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [CH_W-1:0]   win_idx,
  input  logic              win_io,
  input  logic [WS_W-1:0]   win_ws,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              rd,
  input  logic              wr,
  output logic [NUM_CH-1:0] cs_n,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_wait
);

  logic [NUM_CH-1:0] cs_q;
  logic              mreq_q;
  logic              rd_q;
  logic              wr_q;
  logic [WS_W-1:0]   cnt_q;
  logic              req_d;
  logic              req_any;
  logic              start;

  assign req_any = mem_req || io_req;
  assign start   = req_any && !req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= '1;
      mreq_q <= 1'b1;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      cnt_q  <= '0;
      req_d  <= 1'b0;
    end else begin
      req_d <= req_any;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cs_q <= '1;
        if (win_valid) cs_q[win_idx] <= 1'b0;
        mreq_q <= !(win_valid && !win_io);
        rd_q   <= !(win_valid && rd);
        wr_q   <= !(win_valid && wr);
        if (win_valid && start) cnt_q <= win_ws;
      end
    end
  end

  assign cs_n     = cs_q;
  assign mreq_n   = mreq_q;
  assign rd_n     = rd_q;
  assign wr_n     = wr_q;
  assign bus_wait = (cnt_q != '0);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n)); // R6
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> (mreq_n && rd_n && wr_n)); // R7
  AST_MREQ_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !mreq_n |-> !(&cs_n)); // R7
  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    bus_wait |=> ($stable(cs_n) && $stable(mreq_n) && $stable(rd_n) && $stable(wr_n))); // R9
  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (rst)
    bus_wait |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 24,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              rd,
  input  logic              wr,
  input  logic              ram_hit,
  input  logic              flash_hit,
  output logic [NUM_CH-1:0] cs_n,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_wait
);

  chan_regs_t [NUM_CH-1:0]     regs;
  logic [NUM_CH-1:0]           hit;
  logic [NUM_CH-1:0]           is_io;
  logic [NUM_CH-1:0][WS_W-1:0] ws;
  logic                        win_valid;
  logic [CH_W-1:0]             win_idx;
  logic                        win_io;
  logic [WS_W-1:0]             win_ws;

  csel_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .chan  (cfg_chan),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .regs  (regs)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_match
    csel_chan_match #(.ADDR_W(ADDR_W)) u_match (
      .regs      (regs[g]),
      .addr      (addr),
      .mem_req   (mem_req),
      .io_req    (io_req),
      .ram_hit   (ram_hit),
      .flash_hit (flash_hit),
      .hit       (hit[g]),
      .is_io     (is_io[g]),
      .ws        (ws[g])
    );
  end

  csel_prio #(.NUM_CH(NUM_CH)) u_prio (
    .hit       (hit),
    .is_io     (is_io),
    .ws        (ws),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_io    (win_io),
    .win_ws    (win_ws)
  );

  csel_strobe #(.NUM_CH(NUM_CH)) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_io    (win_io),
    .win_ws    (win_ws),
    .mem_req   (mem_req),
    .io_req    (io_req),
    .rd        (rd),
    .wr        (wr),
    .cs_n      (cs_n),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_wait  (bus_wait)
  );

  AST_IO_NO_MREQ: assert property (@(posedge clk) disable iff (rst)
    (!bus_wait && win_valid && win_io) |=> mreq_n); // R4
  AST_ONCHIP_BLOCKS_MEM: assert property (@(posedge clk) disable iff (rst)
    (!bus_wait && (ram_hit || flash_hit) && !io_req) |=> (&cs_n)); // R5

endmodule

// File: tb/csel_decoder_bench.sv
module csel_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] addr = '0;
  logic        mem_req = 1'b0;
  logic        io_req = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic        ram_hit = 1'b0;
  logic        flash_hit = 1'b0;
  logic [3:0]  cs_n;
  logic        mreq_n;
  logic        rd_n;
  logic        wr_n;
  logic        bus_wait;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_decoder u_csel_decoder (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_chan  (cfg_chan),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .addr      (addr),
    .mem_req   (mem_req),
    .io_req    (io_req),
    .rd        (rd),
    .wr        (wr),
    .ram_hit   (ram_hit),
    .flash_hit (flash_hit),
    .cs_n      (cs_n),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_wait  (bus_wait)
  );

  // {addr, mem_req io_req rd wr ram_hit flash_hit, exp cs_n, exp mreq_n rd_n wr_n}
  localparam logic [36:0] VEC [NVEC] = '{
    {24'h150000, 6'b101000, 4'b1110, 3'b001},
    {24'h100000, 6'b100100, 4'b1110, 3'b010},
    {24'h1F0000, 6'b101000, 4'b1110, 3'b001},
    {24'h0F0000, 6'b101000, 4'b1111, 3'b111},
    {24'h200000, 6'b101000, 4'b1101, 3'b001},
    {24'h2F0000, 6'b101000, 4'b1101, 3'b001},
    {24'h300000, 6'b101000, 4'b1111, 3'b111},
    {24'h1A0000, 6'b101010, 4'b1111, 3'b111},
    {24'h1A0000, 6'b101001, 4'b1111, 3'b111},
    {24'h1A0000, 6'b101000, 4'b1110, 3'b001},
    {24'h004000, 6'b011000, 4'b1011, 3'b101},
    {24'h004000, 6'b010110, 4'b1011, 3'b110},
    {24'h004100, 6'b011000, 4'b1111, 3'b111},
    {24'h404000, 6'b101000, 4'b1111, 3'b111},
    {24'h850000, 6'b101000, 4'b1111, 3'b111},
    {24'h150000, 6'b001000, 4'b1111, 3'b111},
    {24'h150000, 6'b100000, 4'b1110, 3'b011}
  };

  localparam string VTAG [NVEC] = '{
    "R3", "R3", "R3", "R3", "R3", "R3", "R3", "R5", "R5", "R6",
    "R4", "R5", "R4", "R4", "R2", "R7", "R7"
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] ch, input logic [1:0] sel,
                           input logic [7:0] data);
    cfg_we    = 1'b1;
    cfg_chan  = ch;
    cfg_sel   = sel;
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic check_bus(input string tag, input logic [3:0] ecs,
                           input logic [2:0] estr, input logic ewait);
    check(tag, "cs_n", 32'(cs_n), 32'(ecs));
    check(tag, "mreq_n/rd_n/wr_n", 32'({mreq_n, rd_n, wr_n}), 32'(estr));
    check(tag, "bus_wait", 32'(bus_wait), 32'(ewait));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, with an address every reset window covers and no channel enabled (R2)
    mem_req = 1'b1; rd = 1'b1; addr = 24'h000000;
    @(negedge clk);
    check_bus("R1", 4'b1111, 3'b111, 1'b0);
    mem_req = 1'b0; rd = 1'b0;

    // R10: program the channels through the write port
    cfg_write(2'd0, 2'd1, 8'h10);
    cfg_write(2'd0, 2'd2, 8'h1F);
    cfg_write(2'd0, 2'd0, 8'h08);
    cfg_write(2'd1, 2'd1, 8'h18);
    cfg_write(2'd1, 2'd2, 8'h2F);
    cfg_write(2'd1, 2'd0, 8'h08);
    cfg_write(2'd2, 2'd3, 8'h40);
    cfg_write(2'd2, 2'd0, 8'h18);
    cfg_write(2'd3, 2'd1, 8'h80);
    cfg_write(2'd3, 2'd2, 8'h8F);

    for (int i = 0; i < NVEC; i++) begin
      addr = VEC[i][36:13];
      {mem_req, io_req, rd, wr, ram_hit, flash_hit} = VEC[i][12:7];
      @(negedge clk);
      check_bus(VTAG[i], VEC[i][6:3], VEC[i][2:0], 1'b0);
    end

    // R2: enabling channel 3 makes its window live
    mem_req = 1'b0; io_req = 1'b0; ram_hit = 1'b0; flash_hit = 1'b0;
    cfg_write(2'd3, 2'd0, 8'h08);
    mem_req = 1'b1; rd = 1'b1; wr = 1'b0; addr = 24'h850000;
    @(negedge clk);
    check_bus("R2", 4'b0111, 3'b001, 1'b0);

    // R8: a bound rewrite is used from the next cycle
    cfg_write(2'd0, 2'd1, 8'h16);
    addr = 24'h150000;
    @(negedge clk);
    check_bus("R8", 4'b1111, 3'b111, 1'b0);

    // R9: three wait states on channel 3, outputs frozen while counting
    mem_req = 1'b0;
    cfg_write(2'd3, 2'd0, 8'h68);
    mem_req = 1'b1; rd = 1'b1; addr = 24'h850000;
    @(negedge clk);
    check_bus("R9", 4'b0111, 3'b001, 1'b1);
    addr = 24'h200000;
    @(negedge clk);
    check_bus("R9", 4'b0111, 3'b001, 1'b1);
    @(negedge clk);
    check_bus("R9", 4'b0111, 3'b001, 1'b1);
    @(negedge clk);
    check_bus("R9", 4'b0111, 3'b001, 1'b0);
    @(negedge clk);
    check_bus("R9", 4'b1101, 3'b001, 1'b0);

    // R1: reset clears the registers again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    addr = 24'h850000;
    @(negedge clk);
    check_bus("R1", 4'b1111, 3'b111, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule